// File: doc/BRIEF.md
# Multi-Channel Window Limit Monitor

This block watches eleven supply and sensor channels against programmable windows. Every channel owns four 16-bit limit words: two lower bounds and two upper bounds. A sample arrives as a one-cycle strobe carrying a channel tag and a 10-bit code. The block compares the sample against all four limits of that channel in the same cycle.

Each limit word carries its own action bits beside its 10-bit threshold. A violated limit whose action bits ask for a reset, a power-off or a shutdown counts as critical. A critical violation latches a sticky fault bit for its channel and pulses the matching action output. A limit that only carries the healthy-signal bit, or no action bit at all, raises nothing.

Software programs the limits through a byte-wide register port. The latched faults form a 16-bit word that is read as two bytes, upper byte first. Reading the lower byte clears exactly the faults that the preceding upper-byte read captured.

Top module: `lc_limit_monitor`

## Requirements
- R1: Limit k (0..3) of channel c (0..10) is stored at byte address 0x80 + 8*c + 2*k (bits 15..8) and the next address (bits 7..0); a write to either byte changes only that byte, and reads return the stored byte. Limits 0 and 1 are lower bounds, limits 2 and 3 are upper bounds.
- R2: After reset all limits read 0x00, both status bytes read 0x00, reg_rdata is 0x00 and no action output is high.
- R3: A lower bound is violated only when the sample is strictly less than the threshold; an equal sample does not violate it.
- R4: An upper bound is violated only when the sample is strictly greater than the threshold, and only after at least one of its two bytes has been written since reset.
- R5: A violated limit is critical when bit 15 (reset), bit 13 (power-off) or bit 12 (shutdown) is set; a violation of a limit with only bit 14 (healthy) set, or no action bit, sets no fault and pulses no output.
- R6: Channel c sets fault bit c (channels A..F in bits 0..5, VDD bit 6, 12V bit 7, temperature bit 8, AIN1 bit 9, AIN2 bit 10); address 0x10 reads fault bits 15..8 and address 0x11 reads bits 7..0; bits 15..11 always read 0.
- R7: Fault bits are sticky. A read of 0x10 captures the whole fault word; a following read of 0x11 returns the captured lower byte and clears exactly the captured bits. Faults set after the capture stay set, and a fault set in the same cycle as the clear stays set.
- R8: In the cycle after a sample strobe, trig_reset, trig_poweroff and trig_shutdown are each high for one cycle when any violated limit of that channel has bit 15, bit 13 or bit 12 set, respectively; several may be high together.
- R9: Samples whose channel tag is 11 or more are ignored; writes to addresses outside the limit area and the two status addresses change nothing, and reads of unmapped addresses return 0x00.
- R10: reg_rdata shows the read result in the cycle after reg_rd and holds it until the next read.
- R11: Only bits 9..0 of a limit word form the threshold; bits 11 and 10 do not affect the comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| smp_valid | input | 1 | Sample strobe |
| smp_ch | input | 4 | Channel tag of the sample |
| smp_data | input | 10 | Sample code |
| trig_reset | output | 1 | One-cycle reset action pulse |
| trig_poweroff | output | 1 | One-cycle power-off action pulse |
| trig_shutdown | output | 1 | One-cycle shutdown action pulse |

## Verification
The bench builds the block with its default parameters: eleven channels, 10-bit samples and an 8-bit address. With these values the four-bit channel tag has unused codes 11 to 15, so ignored tags, the highest real channel (AIN2 in bit 10 of the upper status byte) and the limit area's upper edge at 0xD7/0xD8 all lie within reach. Thresholds near the 10-bit range and words with bits 11..10 set show that only the low ten bits are compared.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int CH_COUNT    = 11;
    localparam int SMP_BITS    = 10;
    localparam int LIM_BITS    = 16;
    localparam int LIMS_PER_CH = 4;
    localparam int UNDER_LIMS  = 2;
    localparam int ADDR_BITS   = 8;
    localparam int BYTE_BITS   = 8;
    localparam int FAULT_BITS  = 16;

    localparam logic [ADDR_BITS-1:0] LIM_BASE_ADDR = 8'h80;
    localparam logic [ADDR_BITS-1:0] STAT_HI_ADDR  = 8'h10;
    localparam logic [ADDR_BITS-1:0] STAT_LO_ADDR  = 8'h11;

    // action field positions inside a limit word
    localparam int BIT_RST     = 15;
    localparam int BIT_HEALTHY = 14;
    localparam int BIT_PWR     = 13;
    localparam int BIT_SD      = 12;

    typedef struct packed {
        logic crit;
        logic rst;
        logic pwr;
        logic sd;
    } act_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_LIMIT,
        SRC_STAT_HI,
        SRC_STAT_LO
    } rd_src_e;

    function automatic logic word_is_crit(input logic [LIM_BITS-1:0] w);
        return w[BIT_RST] | w[BIT_PWR] | w[BIT_SD];
    endfunction

endpackage

// File: rtl/lc_limit_bank.sv
module lc_limit_bank
    import lc_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int LPC    = LIMS_PER_CH,
    parameter int ADDR_W = ADDR_BITS,
    parameter int CH_W   = $clog2(CH_COUNT),
    parameter logic [ADDR_W-1:0] BASE = LIM_BASE_ADDR
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTE_BITS-1:0]       wdata,
    output logic                       hit,
    output logic [BYTE_BITS-1:0]       rd_byte,
    input  logic [CH_W-1:0]            sel_ch,
    output logic [LPC-1:0][LIM_BITS-1:0] sel_words,
    output logic [LPC-1:0]             sel_armed
);

    localparam int BYTES_PER_LIM = LIM_BITS / BYTE_BITS;
    localparam int BYTE_SEL_W    = $clog2(BYTES_PER_LIM);
    localparam int LIM_SEL_W     = $clog2(LPC);
    localparam int CH_SHIFT      = BYTE_SEL_W + LIM_SEL_W;
    localparam int OFF_CH_W      = ADDR_W - CH_SHIFT;

    logic [LIM_BITS-1:0] lim_q   [NUM_CH][LPC];
    logic                armed_q [NUM_CH][LPC];

    logic [ADDR_W-1:0]    off;
    logic [OFF_CH_W-1:0]  off_ch;
    logic [CH_W-1:0]      dec_ch;
    logic [LIM_SEL_W-1:0] dec_lim;
    logic                 dec_lo;
    logic [LIM_BITS-1:0]  rd_word;

    assign off     = addr - BASE;
    assign off_ch  = off[ADDR_W-1:CH_SHIFT];
    assign dec_ch  = off[CH_SHIFT+CH_W-1:CH_SHIFT];
    assign dec_lim = off[CH_SHIFT-1:BYTE_SEL_W];
    assign dec_lo  = off[0];
    assign hit     = (addr >= BASE) && (int'(off_ch) < NUM_CH);

    // byte writes; any write to a limit arms it
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int k = 0; k < LPC; k++) begin
                    lim_q[c][k]   <= '0;
                    armed_q[c][k] <= 1'b0;
                end
            end
        end else if (wr_en && hit) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int k = 0; k < LPC; k++) begin
                    if (int'(dec_ch) == c && int'(dec_lim) == k) begin
                        if (dec_lo)
                            lim_q[c][k][BYTE_BITS-1:0] <= wdata;
                        else
                            lim_q[c][k][LIM_BITS-1:BYTE_BITS] <= wdata;
                        armed_q[c][k] <= 1'b1;
                    end
                end
            end
        end
    end

    // register-port read mux
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < LPC; k++) begin
                if (int'(dec_ch) == c && int'(dec_lim) == k)
                    rd_word = lim_q[c][k];
            end
        end
        if (!hit)
            rd_byte = '0;
        else if (dec_lo)
            rd_byte = rd_word[BYTE_BITS-1:0];
        else
            rd_byte = rd_word[LIM_BITS-1:BYTE_BITS];
    end

    // sample-side channel select
    always_comb begin
        sel_words = '0;
        sel_armed = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(sel_ch) == c) begin
                for (int k = 0; k < LPC; k++) begin
                    sel_words[k] = lim_q[c][k];
                    sel_armed[k] = armed_q[c][k];
                end
            end
        end
    end

endmodule

// File: rtl/lc_window_cmp.sv
module lc_window_cmp
    import lc_pkg::*;
#(
    parameter int SMP_W     = SMP_BITS,
    parameter int LPC       = LIMS_PER_CH,
    parameter int UNDER_CNT = UNDER_LIMS
) (
    input  logic [SMP_W-1:0]             sample,
    input  logic [LPC-1:0][LIM_BITS-1:0] words,
    input  logic [LPC-1:0]               armed,
    output logic [LPC-1:0]               viol,
    output act_t                         act
);

    localparam int GAP_W = BIT_SD - SMP_W;

    logic [LPC-1:0] crit_req;
    logic [LPC-1:0] rst_req;
    logic [LPC-1:0] pwr_req;
    logic [LPC-1:0] sd_req;

    for (genvar k = 0; k < LPC; k++) begin : g_lim
        logic [SMP_W-1:0] thr;
        logic [GAP_W:0]   unused_fields;

        assign thr           = words[k][SMP_W-1:0];
        assign unused_fields = {words[k][BIT_HEALTHY], words[k][BIT_SD-1:SMP_W]};

        if (k < UNDER_CNT) begin : g_under
            // a zero threshold can never be undercut, so no arming needed
            logic unused_arm;
            assign unused_arm = armed[k];
            assign viol[k]    = sample < thr;
        end else begin : g_over
            assign viol[k] = armed[k] && (sample > thr);
        end

        assign crit_req[k] = word_is_crit(words[k]);
        assign rst_req[k]  = words[k][BIT_RST];
        assign pwr_req[k]  = words[k][BIT_PWR];
        assign sd_req[k]   = words[k][BIT_SD];
    end

    assign act.crit = |(viol & crit_req);
    assign act.rst  = |(viol & rst_req);
    assign act.pwr  = |(viol & pwr_req);
    assign act.sd   = |(viol & sd_req);

endmodule

// File: rtl/lc_fault_status.sv
module lc_fault_status
    import lc_pkg::*;
#(
    parameter int FLT_W = FAULT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FLT_W-1:0] set_vec,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [FLT_W-1:0] sticky_q,
    output logic [FLT_W-1:0] snap_q
);

    logic [FLT_W-1:0] clr_vec;
    logic             past_ok;

    assign clr_vec = rd_lo ? snap_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
            snap_q   <= '0;
            past_ok  <= 1'b0;
        end else begin
            // new faults win over a clear in the same cycle
            sticky_q <= (sticky_q & ~clr_vec) | set_vec;
            if (rd_hi)
                snap_q <= sticky_q;
            else if (rd_lo)
                snap_q <= '0;
            past_ok <= 1'b1;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rd_lo)) |-> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R7

    AST_LO_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rd_lo) && ($past(set_vec) == '0)) |-> ((sticky_q & $past(snap_q)) == '0)); // R7

endmodule

// File: rtl/lc_limit_monitor.sv
module lc_limit_monitor
    import lc_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int SMP_W  = SMP_BITS,
    parameter int ADDR_W = ADDR_BITS,
    parameter int FLT_W  = FAULT_BITS,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter logic [ADDR_W-1:0] LIM_BASE = LIM_BASE_ADDR,
    parameter logic [ADDR_W-1:0] STAT_HI  = STAT_HI_ADDR,
    parameter logic [ADDR_W-1:0] STAT_LO  = STAT_LO_ADDR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BYTE_BITS-1:0] reg_wdata,
    output logic [BYTE_BITS-1:0] reg_rdata,
    input  logic                 smp_valid,
    input  logic [CH_W-1:0]      smp_ch,
    input  logic [SMP_W-1:0]     smp_data,
    output logic                 trig_reset,
    output logic                 trig_poweroff,
    output logic                 trig_shutdown
);

    localparam int LPC = LIMS_PER_CH;

    logic                       lim_hit;
    logic [BYTE_BITS-1:0]       lim_byte;
    logic [LPC-1:0][LIM_BITS-1:0] ch_words;
    logic [LPC-1:0]             ch_armed;
    logic [LPC-1:0]             ch_viol;
    act_t                       ch_act;
    logic                       smp_take;
    logic [FLT_W-1:0]           flt_set;
    logic [FLT_W-1:0]           flt_word;
    logic [FLT_W-1:0]           flt_snap;
    rd_src_e                    rd_src;
    logic                       rd_hi;
    logic                       rd_lo;
    logic                       past_ok;

    lc_limit_bank #(
        .NUM_CH (NUM_CH),
        .LPC    (LPC),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W),
        .BASE   (LIM_BASE)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .hit       (lim_hit),
        .rd_byte   (lim_byte),
        .sel_ch    (smp_ch),
        .sel_words (ch_words),
        .sel_armed (ch_armed)
    );

    lc_window_cmp #(
        .SMP_W     (SMP_W),
        .LPC       (LPC),
        .UNDER_CNT (UNDER_LIMS)
    ) u_cmp (
        .sample (smp_data),
        .words  (ch_words),
        .armed  (ch_armed),
        .viol   (ch_viol),
        .act    (ch_act)
    );

    // tags beyond the channel count are dropped
    assign smp_take = smp_valid && (int'(smp_ch) < NUM_CH);

    always_comb begin
        flt_set = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(smp_ch) == i)
                flt_set[i] = smp_take && ch_act.crit;
        end
    end

    always_comb begin
        if (lim_hit)
            rd_src = SRC_LIMIT;
        else if (reg_addr == STAT_HI)
            rd_src = SRC_STAT_HI;
        else if (reg_addr == STAT_LO)
            rd_src = SRC_STAT_LO;
        else
            rd_src = SRC_NONE;
    end

    assign rd_hi = reg_rd && (rd_src == SRC_STAT_HI);
    assign rd_lo = reg_rd && (rd_src == SRC_STAT_LO);

    lc_fault_status #(
        .FLT_W (FLT_W)
    ) u_faults (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (flt_set),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo),
        .sticky_q (flt_word),
        .snap_q   (flt_snap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata     <= '0;
            trig_reset    <= 1'b0;
            trig_poweroff <= 1'b0;
            trig_shutdown <= 1'b0;
            past_ok       <= 1'b0;
        end else begin
            if (reg_rd) begin
                unique case (rd_src)
                    SRC_LIMIT:   reg_rdata <= lim_byte;
                    SRC_STAT_HI: reg_rdata <= flt_word[FLT_W-1:BYTE_BITS];
                    SRC_STAT_LO: reg_rdata <= flt_snap[BYTE_BITS-1:0];
                    default:     reg_rdata <= '0;
                endcase
            end
            trig_reset    <= smp_take && ch_act.rst;
            trig_poweroff <= smp_take && ch_act.pwr;
            trig_shutdown <= smp_take && ch_act.sd;
            past_ok       <= 1'b1;
        end
    end

    AST_TRIG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (trig_reset || trig_poweroff || trig_shutdown)) |-> $past(smp_valid)); // R8

    AST_TRIG_LATCHES_FAULT: assert property (@(posedge clk) disable iff (rst)
        (trig_reset || trig_poweroff || trig_shutdown) |-> (flt_word != '0)); // R5

    AST_BAD_TAG_SILENT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(smp_valid) && (int'($past(smp_ch)) >= NUM_CH))
            |-> !(trig_reset || trig_poweroff || trig_shutdown)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(reg_rd)) |-> $stable(reg_rdata)); // R10

    AST_HIGH_FAULTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        flt_word[FLT_W-1:NUM_CH] == '0); // R6

endmodule

// File: tb/lc_limit_monitor_bench.sv
`timescale 1ns/1ps
module lc_limit_monitor_bench;

    localparam time CLK_PERIOD = 20ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata;
    logic [7:0] reg_rdata;
    logic       smp_valid;
    logic [3:0] smp_ch;
    logic [9:0] smp_data;
    logic       trig_reset, trig_poweroff, trig_shutdown;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lc_limit_monitor u_lc_limit_monitor (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .smp_valid     (smp_valid),
        .smp_ch        (smp_ch),
        .smp_data      (smp_data),
        .trig_reset    (trig_reset),
        .trig_poweroff (trig_poweroff),
        .trig_shutdown (trig_shutdown)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr_limit(input int ch, input int k, input logic [15:0] w);
        wr(8'(8'h80 + 8 * ch + 2 * k), w[15:8]);
        wr(8'(8'h80 + 8 * ch + 2 * k + 1), w[7:0]);
    endtask

    // strobe one sample; triggers {reset,poweroff,shutdown} expected next cycle, then low
    task automatic sample(input string tag, input int ch, input int val, input logic [2:0] exp);
        @(negedge clk);
        smp_valid = 1'b1; smp_ch = 4'(ch); smp_data = 10'(val);
        @(negedge clk);
        smp_valid = 1'b0;
        chk({tag, " trig"}, {13'd0, trig_reset, trig_poweroff, trig_shutdown}, {13'd0, exp});
        @(negedge clk);
        chk({tag, " trig pulse"}, {13'd0, trig_reset, trig_poweroff, trig_shutdown}, 16'd0);
    endtask

    task automatic status(input string tag, input logic [7:0] exp_hi, input logic [7:0] exp_lo);
        logic [7:0] d;
        rd(8'h10, d);
        chk({tag, " status hi"}, {8'd0, d}, {8'd0, exp_hi});
        rd(8'h11, d);
        chk({tag, " status lo"}, {8'd0, d}, {8'd0, exp_lo});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R2 rdata after reset", {8'd0, reg_rdata}, 16'd0);
        chk("R2 triggers after reset", {13'd0, trig_reset, trig_poweroff, trig_shutdown}, 16'd0);
        rd(8'h80, d); chk("R2 limit 0x80", {8'd0, d}, 16'd0);
        rd(8'hD7, d); chk("R2 limit 0xD7", {8'd0, d}, 16'd0);
        status("R2", 8'h00, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(8'h96, 8'hA1);
        wr(8'h97, 8'h23);
        rd(8'h96, d); chk("R1 ch2 lim3 high byte", {8'd0, d}, 16'h00A1);
        repeat (2) @(negedge clk);
        chk("R10 rdata holds", {8'd0, reg_rdata}, 16'h00A1);
        rd(8'h97, d); chk("R1 ch2 lim3 low byte", {8'd0, d}, 16'h0023);
        rd(8'h94, d); chk("R1 neighbour untouched", {8'd0, d}, 16'd0);
        wr(8'hD8, 8'h55);
        rd(8'hD8, d); chk("R9 unmapped read", {8'd0, d}, 16'd0);
        wr(8'h10, 8'hFF);
        rd(8'h20, d); chk("R9 gap read", {8'd0, d}, 16'd0);
        status("R9 status write ignored", 8'h00, 8'h00);
    endtask

    task automatic t_under();
        wr_limit(0, 0, 16'h8100);
        sample("R3 equal to lower bound", 0, 256, 3'b000);
        status("R3 equal no fault", 8'h00, 8'h00);
        sample("R3 R8 below lower bound", 0, 255, 3'b100);
        status("R6 ch0 fault", 8'h00, 8'h01);
        status("R7 cleared", 8'h00, 8'h00);
    endtask

    task automatic t_over();
        sample("R4 disarmed upper", 8, 5, 3'b000);
        status("R4 disarmed no fault", 8'h00, 8'h00);
        wr_limit(8, 2, 16'h2200);
        sample("R4 equal to upper bound", 8, 512, 3'b000);
        sample("R4 R8 above upper bound", 8, 513, 3'b010);
        status("R6 temperature bit 8", 8'h01, 8'h00);
        status("R7 bit 8 cleared", 8'h00, 8'h00);
    endtask

    task automatic t_noncrit();
        wr_limit(3, 1, 16'h4300);
        sample("R5 healthy-only violation", 3, 700, 3'b000);
        status("R5 no fault", 8'h00, 8'h00);
    endtask

    task automatic t_thrbits();
        wr_limit(10, 3, 16'h1C05);
        sample("R11 equal to low ten bits", 10, 5, 3'b000);
        sample("R11 R8 above low ten bits", 10, 6, 3'b001);
        status("R6 AIN2 bit 10", 8'h04, 8'h00);
        status("R7 bit 10 cleared", 8'h00, 8'h00);
    endtask

    task automatic t_multi();
        wr_limit(5, 2, 16'hB010);
        sample("R8 all three actions", 5, 17, 3'b111);
        sample("R8 at threshold none", 5, 16, 3'b000);
        status("R6 ch5 bit 5", 8'h00, 8'h20);
    endtask

    task automatic t_badch();
        sample("R9 tag 11", 11, 1023, 3'b000);
        sample("R9 tag 15", 15, 0, 3'b000);
        status("R9 no fault", 8'h00, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        wr_limit(1, 0, 16'h8100);
        sample("R7 ch0 fault", 0, 10, 3'b100);
        rd(8'h10, d); chk("R7 capture hi", {8'd0, d}, 16'd0);
        sample("R7 ch1 fault after capture", 1, 10, 3'b100);
        rd(8'h11, d); chk("R7 lo returns captured", {8'd0, d}, 16'h0001);
        status("R7 late fault kept", 8'h00, 8'h02);
        status("R7 all clear", 8'h00, 8'h00);
        sample("R7 ch0 again", 0, 10, 3'b100);
        rd(8'h10, d); chk("R7 capture hi 2", {8'd0, d}, 16'd0);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 8'h11;
        smp_valid = 1'b1; smp_ch = 4'd0; smp_data = 10'd10;
        @(negedge clk);
        reg_rd = 1'b0; smp_valid = 1'b0;
        chk("R7 lo read during set", {8'd0, reg_rdata}, 16'h0001);
        chk("R8 trig during clear", {13'd0, trig_reset, trig_poweroff, trig_shutdown}, 16'h0004);
        status("R7 set wins over clear", 8'h00, 8'h01);
        status("R7 final clear", 8'h00, 8'h00);
    endtask

    initial begin
        rst = 1'b1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        smp_valid = 1'b0; smp_ch = '0; smp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_under();
        t_over();
        t_noncrit();
        t_thrbits();
        t_multi();
        t_badch();
        t_sticky();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule